// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits between a clock synthesizer and its output drivers. It turns groups of derived clocks on and off in response to two asynchronous, active-low stop requests and to one enable bit per output. A processor-side stop request silences the gated processor clock, the interrupt-controller clock and every memory clock. A bus-side stop request silences the gated bus clocks. One processor clock and one bus clock are free-running: the stop requests never touch them, and only their own enable bits can hold them low.

Each stop request passes through two flops clocked by the free-running bus clock. The result is then captured by a falling-edge enable flop in the domain of the clock being gated, and that flop drives an AND gate. Because of this path, a change of run/stop state waits for a bus-clock rising edge and then a falling edge of the affected clock. Every stopped output therefore rests low, and no high phase is ever cut short when a clock stops or restarts. A latched mode bit removes the bus-side stop function. A tristate-all bit drops the shared output enable.

Top module: `clock_stop_gate`

## Requirements
- R1: While `rst_n` is low, every clock output is held at 0.
- R2: A low `cpu_stop_req_n` holds `cpu_clk_o`, `apic_clk_o` and all `sdram_clk_o` bits at 0. A change of that input is seen on the second rising edge of `clk_pci_src` after the change. It reaches an output at the first falling edge of that output's source clock after that rising edge, so the output's next high phase shows the new state.
- R3: `cpu_free_clk_o` and `pci_free_clk_o` follow their source clocks whatever the stop inputs are, as long as their enable bits are 1.
- R4: With `mode_sel` = 0, a low `pci_stop_req_n` holds every `pci_clk_o` bit at 0. It uses the same two-edge synchronisation and falling-edge takeover as R2, with `clk_pci_src` as the gated clock.
- R5: With `mode_sel` = 1, `pci_stop_req_n` has no effect and the enabled `pci_clk_o` bits keep running.
- R6: A gated output is 0 throughout any stopped interval. While it runs, each high phase of the output matches a full high phase of its source clock, including the first phase after a restart and the last phase before a stop.
- R7: An output runs only when its enable bit is 1 and its stop input (if any) allows it. A change of an enable bit takes effect at the next falling edge of that output's source clock.
- R8: `out_en_o` is 0 while `tristate_all` is 1 and 1 otherwise, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_src | input | 1 | Processor/memory source clock |
| clk_pci_src | input | 1 | Free-running bus source clock, also the synchroniser clock |
| clk_ref_src | input | 1 | Reference source for the interrupt-controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_req_n | input | 1 | Asynchronous active-low processor-group stop |
| pci_stop_req_n | input | 1 | Asynchronous active-low bus-group stop |
| mode_sel | input | 1 | Latched mode, 1 disables the bus stop function |
| tristate_all | input | 1 | 1 puts all outputs in high impedance via out_en_o |
| en_cpu_free | input | 1 | Enable of the free-running processor clock |
| en_cpu_gated | input | 1 | Enable of the gated processor clock |
| en_apic | input | 1 | Enable of the interrupt-controller clock |
| en_sdram | input | NUM_SDRAM | Per-output memory clock enables |
| en_pci_free | input | 1 | Enable of the free-running bus clock |
| en_pci | input | NUM_PCI | Per-output bus clock enables |
| cpu_free_clk_o | output | 1 | Free-running processor clock |
| cpu_clk_o | output | 1 | Stoppable processor clock |
| apic_clk_o | output | 1 | Stoppable interrupt-controller clock |
| sdram_clk_o | output | NUM_SDRAM | Stoppable memory clocks |
| pci_free_clk_o | output | 1 | Free-running bus clock |
| pci_clk_o | output | NUM_PCI | Stoppable bus clocks |
| out_en_o | output | 1 | Shared output-driver enable |

## Verification
Each stop input is toggled alone, then both are toggled together. This separates wrong grouping (a stop reaching the other group or a free clock) from correct gating. Outputs are sampled in the high phase on the second bus edge after a stop change and again one source period later. This tells a correct two-flop-plus-falling-edge latency apart from one that is a cycle early or a cycle late. Samples near the start and near the end of a high phase show whether a phase was shortened. A stop request with the mode bit set, and a single cleared memory enable among set ones, show that masking works per output and per mode.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int NUM_STOP = 2;
    localparam int CPU_IDX  = 0;
    localparam int PCI_IDX  = 1;

    typedef struct packed {
        logic [NUM_STOP-1:0] meta;
        logic [NUM_STOP-1:0] stable;
    } sync_state_t;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync
    import clkstop_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_n,
    input  logic [NUM_STOP-1:0] req_n_i,
    output logic [NUM_STOP-1:0] allow_o
);

    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = req_n_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign allow_o = st_q.stable;

    // checker: edges seen since reset release
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk_i) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (allow_o == $past(req_n_i, 2))); // R2

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] run_i,
    output logic [WIDTH-1:0] gclk_o
);

    logic [WIDTH-1:0] en_d, en_q;

    always_comb begin
        en_d = run_i;
    end

    // enable changes only while the source clock is low
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign gclk_o = {WIDTH{clk_i}} & en_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        AST_HELD_LOW: assert property (@(negedge clk_i) disable iff (!rst_n)
            !run_i[i] |=> !gclk_o[i]); // R6
        AST_FULL_HIGH: assert property (@(negedge clk_i) disable iff (!rst_n)
            run_i[i] |=> gclk_o[i]); // R6
    end

endmodule

// File: rtl/clock_stop_gate.sv
module clock_stop_gate
    import clkstop_pkg::*;
#(
    parameter int NUM_SDRAM = 13,
    parameter int NUM_PCI   = 5
) (
    input  logic                 clk_cpu_src,
    input  logic                 clk_pci_src,
    input  logic                 clk_ref_src,
    input  logic                 rst_n,
    input  logic                 cpu_stop_req_n,
    input  logic                 pci_stop_req_n,
    input  logic                 mode_sel,
    input  logic                 tristate_all,
    input  logic                 en_cpu_free,
    input  logic                 en_cpu_gated,
    input  logic                 en_apic,
    input  logic [NUM_SDRAM-1:0] en_sdram,
    input  logic                 en_pci_free,
    input  logic [NUM_PCI-1:0]   en_pci,
    output logic                 cpu_free_clk_o,
    output logic                 cpu_clk_o,
    output logic                 apic_clk_o,
    output logic [NUM_SDRAM-1:0] sdram_clk_o,
    output logic                 pci_free_clk_o,
    output logic [NUM_PCI-1:0]   pci_clk_o,
    output logic                 out_en_o
);

    localparam int CPU_GRP_W = NUM_SDRAM + 1;

    logic [NUM_STOP-1:0]  allow;
    logic                 cpu_ok, pci_ok;
    logic [CPU_GRP_W-1:0] cpu_run_d, cpu_gclk;
    logic [NUM_PCI-1:0]   pci_run_d;
    logic                 apic_run_d;

    clkstop_sync u_sync (
        .clk_i   (clk_pci_src),
        .rst_n   (rst_n),
        .req_n_i ({pci_stop_req_n, cpu_stop_req_n}),
        .allow_o (allow)
    );

    always_comb begin
        cpu_ok     = allow[CPU_IDX];
        pci_ok     = allow[PCI_IDX] | mode_sel;
        cpu_run_d  = {en_sdram, en_cpu_gated} & {CPU_GRP_W{cpu_ok}};
        apic_run_d = en_apic & cpu_ok;
        pci_run_d  = en_pci & {NUM_PCI{pci_ok}};
    end

    clkstop_gate #(.WIDTH(CPU_GRP_W)) u_cpu_grp (
        .clk_i (clk_cpu_src), .rst_n (rst_n),
        .run_i (cpu_run_d),   .gclk_o (cpu_gclk)
    );

    clkstop_gate #(.WIDTH(1)) u_apic (
        .clk_i (clk_ref_src), .rst_n (rst_n),
        .run_i (apic_run_d),  .gclk_o (apic_clk_o)
    );

    clkstop_gate #(.WIDTH(NUM_PCI)) u_pci_grp (
        .clk_i (clk_pci_src), .rst_n (rst_n),
        .run_i (pci_run_d),   .gclk_o (pci_clk_o)
    );

    clkstop_gate #(.WIDTH(1)) u_cpu_free (
        .clk_i (clk_cpu_src), .rst_n (rst_n),
        .run_i (en_cpu_free), .gclk_o (cpu_free_clk_o)
    );

    clkstop_gate #(.WIDTH(1)) u_pci_free (
        .clk_i (clk_pci_src), .rst_n (rst_n),
        .run_i (en_pci_free), .gclk_o (pci_free_clk_o)
    );

    assign cpu_clk_o   = cpu_gclk[0];
    assign sdram_clk_o = cpu_gclk[CPU_GRP_W-1:1];
    assign out_en_o    = ~tristate_all;

    AST_PCI_STOP_MASKED: assert property (@(negedge clk_pci_src) disable iff (!rst_n)
        ($past(rst_n) && mode_sel && $past(mode_sel) && (&en_pci) && $past(&en_pci))
        |-> (&pci_clk_o)); // R5

    AST_FREE_CPU_RUNS: assert property (@(negedge clk_cpu_src) disable iff (!rst_n)
        ($past(rst_n) && en_cpu_free && $past(en_cpu_free)) |-> cpu_free_clk_o); // R3

endmodule

// File: tb/clock_stop_gate_bench.sv
`timescale 1ns/100ps
module clock_stop_gate_bench;

    localparam int NS = 13;
    localparam int NP = 5;

    logic clk_cpu = 1'b0;
    logic clk_pci = 1'b0;
    logic clk_ref = 1'b0;
    logic rst_n, cpu_stop_n, pci_stop_n, mode_sel, tri_all;
    logic en_cpuf, en_cpu, en_apic, en_pcif;
    logic [NS-1:0] en_sd;
    logic [NP-1:0] en_pc;
    logic cpuf_o, cpu_o, apic_o, pcif_o, oe_o;
    logic [NS-1:0] sd_o;
    logic [NP-1:0] pc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk_cpu = ~clk_cpu;           // 250 MHz
    always @(posedge clk_cpu) clk_pci <= ~clk_pci;
    always #3 clk_ref = ~clk_ref;

    clock_stop_gate #(.NUM_SDRAM(NS), .NUM_PCI(NP)) u_clock_stop_gate (
        .clk_cpu_src(clk_cpu), .clk_pci_src(clk_pci), .clk_ref_src(clk_ref),
        .rst_n(rst_n), .cpu_stop_req_n(cpu_stop_n), .pci_stop_req_n(pci_stop_n),
        .mode_sel(mode_sel), .tristate_all(tri_all),
        .en_cpu_free(en_cpuf), .en_cpu_gated(en_cpu), .en_apic(en_apic),
        .en_sdram(en_sd), .en_pci_free(en_pcif), .en_pci(en_pc),
        .cpu_free_clk_o(cpuf_o), .cpu_clk_o(cpu_o), .apic_clk_o(apic_o),
        .sdram_clk_o(sd_o), .pci_free_clk_o(pcif_o), .pci_clk_o(pc_o),
        .out_en_o(oe_o)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic wait_pci(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_pci);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            #3.3;
            chk("R1 cpu group in reset", {cpu_o, sd_o, apic_o}, 0);
            chk("R1 pci group in reset", {pc_o, pcif_o, cpuf_o}, 0);
        end
        @(negedge clk_pci); #1 rst_n = 1'b1;
        wait_pci(4);
    endtask

    task automatic t_running;
        @(posedge clk_cpu); #0.5;
        chk("R6 cpu early high", {cpu_o, sd_o, cpuf_o}, {(NS+2){1'b1}});
        #1.2;
        chk("R6 cpu late high", {cpu_o, sd_o, cpuf_o}, {(NS+2){1'b1}});
        @(negedge clk_cpu); #1;
        chk("R6 cpu low phase", {cpu_o, sd_o}, 0);
        @(posedge clk_pci); #1;
        chk("R4 pci running", {pc_o, pcif_o}, {(NP+1){1'b1}});
    endtask

    task automatic t_cpu_stop;
        int hi_apic = 0;
        int hi_pcif = 0;
        @(negedge clk_pci); #1 cpu_stop_n = 1'b0;
        wait_pci(2); #1;
        chk("R2 cpu not yet stopped", {cpu_o, sd_o}, {(NS+1){1'b1}});
        @(posedge clk_cpu); #1;
        chk("R2 cpu group stopped", {cpu_o, sd_o}, 0);
        chk("R3 free cpu runs", cpuf_o, 1);
        wait_pci(2);
        for (int i = 0; i < 40; i++) begin
            #1;
            if (apic_o) hi_apic++;
            if (pcif_o) hi_pcif++;
        end
        chk("R2 apic held low", hi_apic, 0);
        chk("R3 free pci toggles", (hi_pcif > 0), 1);
        @(negedge clk_pci); #1 cpu_stop_n = 1'b1;
        wait_pci(2); #1;
        chk("R2 cpu not yet restarted", {cpu_o, sd_o}, 0);
        @(posedge clk_cpu); #0.5;
        chk("R6 restart first phase early", {cpu_o, sd_o}, {(NS+1){1'b1}});
        #1.2;
        chk("R6 restart first phase late", {cpu_o, sd_o}, {(NS+1){1'b1}});
        wait_pci(2);
        hi_apic = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (apic_o) hi_apic++;
        end
        chk("R2 apic running again", (hi_apic > 0), 1);
    endtask

    task automatic t_pci_stop;
        @(negedge clk_pci); #1 pci_stop_n = 1'b0;
        wait_pci(2); #1;
        chk("R4 pci not yet stopped", pc_o, {NP{1'b1}});
        @(posedge clk_pci); #1;
        chk("R4 pci stopped", pc_o, 0);
        chk("R3 free pci runs", pcif_o, 1);
        chk("R4 cpu unaffected", cpu_o, 1);
        @(negedge clk_pci); #1 pci_stop_n = 1'b1;
        wait_pci(2); #1;
        chk("R4 pci not yet restarted", pc_o, 0);
        @(posedge clk_pci); #1;
        chk("R4 pci restarted", pc_o, {NP{1'b1}});
    endtask

    task automatic t_mode;
        mode_sel = 1'b1;
        @(negedge clk_pci); #1 pci_stop_n = 1'b0;
        wait_pci(4); #1;
        chk("R5 pci stop ignored", pc_o, {NP{1'b1}});
        wait_pci(1); #3;
        chk("R5 pci still ignored", pc_o, {NP{1'b1}});
        pci_stop_n = 1'b1;
        mode_sel = 1'b0;
        wait_pci(4);
    endtask

    task automatic t_both;
        @(negedge clk_pci); #1 begin cpu_stop_n = 1'b0; pci_stop_n = 1'b0; end
        wait_pci(4); #1;
        chk("R2 both stopped cpu", {cpu_o, sd_o}, 0);
        chk("R4 both stopped pci", pc_o, 0);
        chk("R3 both free run", {cpuf_o, pcif_o}, 2'b11);
        @(negedge clk_pci); #1 begin cpu_stop_n = 1'b1; pci_stop_n = 1'b1; end
        wait_pci(4); #1;
        chk("R2 both released", {cpu_o, sd_o, pc_o}, {(NS+NP+1){1'b1}});
    endtask

    task automatic t_enable;
        @(posedge clk_cpu); #1 en_sd[3] = 1'b0;
        chk("R7 current phase kept", sd_o, {NS{1'b1}});
        @(posedge clk_cpu); #1;
        chk("R7 one sdram disabled", sd_o, 13'h1FF7);
        en_sd[3] = 1'b1;
        @(posedge clk_cpu); #1;
        chk("R7 sdram re-enabled", sd_o, {NS{1'b1}});
        en_pcif = 1'b0;
        wait_pci(2); #1;
        chk("R7 free pci disabled", pcif_o, 0);
        en_pcif = 1'b1;
        wait_pci(2); #1;
        chk("R7 free pci enabled", pcif_o, 1);
    endtask

    task automatic t_tristate;
        chk("R8 drivers on", oe_o, 1);
        #0.7 tri_all = 1'b1; #0.1;
        chk("R8 drivers off", oe_o, 0);
        tri_all = 1'b0; #0.1;
        chk("R8 drivers back on", oe_o, 1);
    endtask

    initial begin
        rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        mode_sel = 1'b0; tri_all = 1'b0;
        en_cpuf = 1'b1; en_cpu = 1'b1; en_apic = 1'b1; en_pcif = 1'b1;
        en_sd = '1; en_pc = '1;
        t_reset();
        t_running();
        t_cpu_stop();
        t_pci_stop();
        t_mode();
        t_both();
        t_enable();
        t_tristate();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule